// File: doc/BRIEF.md
# Voted Latching Alarm State Machine

This block makes the alarm decision for a patient safety chain. Two independent monitor channels each deliver an already qualified fault flag and a flag saying that the channel's input can no longer be trusted (open, saturated or stuck). The block turns these flags into three action outputs: a local alert, a hard action that drives a relay or interlock, and an isolated status line. The isolated status line reads "OK" only when the chain is healthy.

A fault on either channel moves the block into a suspect phase. A confirmed fault needs both channels to agree for a set number of consecutive cycles. A suspect phase that is not confirmed ends after a fixed number of cycles. A confirmed fault latches the alarm. Only a maintenance reset, given while both channels read clean and valid, can release the latch. Loss of validity on any channel leads to a separate untrusted state. That state never shows as healthy and is also left only through a maintenance reset.

Every state change, and every refused maintenance reset, produces a single-cycle report for a logger. The report carries the old state, the new state and a reason code. The report has no back-pressure. The logger must accept a report in any cycle, so a slow logger can never delay a safety action.

Top module: `alarm_vote_fsm`

## Requirements
- R1: While `rst_n` is low, `alert_o`, `hard_act_o`, `iso_ok_o` and `log_valid_o` are all 0. After release, `iso_ok_o` reads 1 from the first clock edge on.
- R2: In Normal (state code 0), a fault flag on either channel moves the block to Suspect (code 1) at the next edge. This is reported with from 0, to 1 and reason 0 (no reason).
- R3: Suspect moves to Confirmed (code 2) only when both channels flag a fault on CONFIRM_CYC consecutive edges spent in Suspect. A single-channel fault, or a break in agreement, never confirms, and a break restarts the count.
- R4: A Suspect phase that is not confirmed returns to Normal after exactly SUSPECT_MAX edges in Suspect, whatever the inputs do. This is reported with reason 1 (lapse).
- R5: Confirmed moves to Latched (code 3) at the next edge. `hard_act_o` is 1 in Latched and in no other state.
- R6: Latched is kept when the fault flags clear and when the invalid flags toggle, and no report is produced in that case.
- R7: A maintenance request in Latched, while every fault and invalid flag is 0, moves the block to Normal with reason 2 (cleared). `hard_act_o` and `alert_o` drop and `iso_ok_o` returns to 1 in the same cycle.
- R8: A maintenance request in Latched or Untrusted while any fault or invalid flag is set leaves the state unchanged. It is reported with from equal to to and reason 3 (rejected).
- R9: An invalid flag on any channel in Normal or Suspect moves the block to Untrusted (code 4) at the next edge. Untrusted shows `alert_o`=1 and `iso_ok_o`=0, and it is left only through a clean maintenance request (reason 2).
- R10: A maintenance request in Normal has no effect: no report is produced and the outputs do not change.
- R11: `alert_o` is 1 in Confirmed, Latched and Untrusted. `iso_ok_o` is 1 only in Normal and Suspect.
- R12: Each report is a one-cycle `log_valid_o` pulse, valid in the first cycle of the new state. Reports appear in the order the transitions occur, and there are no reports other than transitions and rejected requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_fault_i | input | NUM_CH | Qualified fault flag per monitor channel |
| chan_invalid_i | input | NUM_CH | Input-not-trustworthy flag per channel |
| maint_req_i | input | 1 | Maintenance reset request, sampled each edge |
| alert_o | output | 1 | Local alert (buzzer or indicator) |
| hard_act_o | output | 1 | Relay or interlock action |
| iso_ok_o | output | 1 | Isolated status, 1 = healthy, 0 = alarm (fail-safe level) |
| log_valid_o | output | 1 | Transition report strobe |
| log_from_o | output | 3 | Reported old state code |
| log_to_o | output | 3 | Reported new state code |
| log_reason_o | output | 2 | Reported reason code |

## Verification
The assertions assume that every input is a known level that changes only between clock edges and holds steady across each rising edge. They also assume that the maintenance request needs no edge detection, because the block acts on the level seen at each edge. The stimulus changes inputs only on falling edges. It holds the maintenance request high for exactly one cycle at a time, so one request produces exactly one decision. It builds agreement windows cycle by cycle, so that the confirm and lapse edges fall on known cycles.

// File: rtl/alarm_vote_pkg.sv
package alarm_vote_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_SUSPECT   = 3'd1,
    ST_CONFIRMED = 3'd2,
    ST_LATCHED   = 3'd3,
    ST_UNTRUSTED = 3'd4
  } alarm_state_e;

  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_LAPSE  = 2'd1,
    RSN_CLEAR  = 2'd2,
    RSN_REJECT = 2'd3
  } alarm_reason_e;

  typedef struct packed {
    alarm_state_e  from_st;
    alarm_state_e  to_st;
    alarm_reason_e reason;
  } alarm_report_t;

endpackage

// File: rtl/chan_vote.sv
module chan_vote #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] fault_i,
  input  logic [NUM_CH-1:0] invalid_i,
  output logic              any_fault_o,
  output logic              all_fault_o,
  output logic              any_invalid_o
);

  // Running OR / AND chains, one stage per channel.
  logic [NUM_CH:0] or_chain;
  logic [NUM_CH:0] and_chain;
  logic [NUM_CH:0] inv_chain;

  assign or_chain[0]  = 1'b0;
  assign and_chain[0] = 1'b1;
  assign inv_chain[0] = 1'b0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign or_chain[c+1]  = or_chain[c]  | fault_i[c];
    assign and_chain[c+1] = and_chain[c] & fault_i[c];
    assign inv_chain[c+1] = inv_chain[c] | invalid_i[c];
  end

  assign any_fault_o   = or_chain[NUM_CH];
  assign all_fault_o   = and_chain[NUM_CH];
  assign any_invalid_o = inv_chain[NUM_CH];

endmodule

// File: rtl/suspect_timer.sv
module suspect_timer #(
  parameter int CONFIRM_CYC = 4,
  parameter int SUSPECT_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_suspect_i,
  input  logic all_fault_i,
  output logic confirm_hit_o,
  output logic lapse_hit_o
);

  localparam int CW = $clog2(SUSPECT_MAX + 1);
  localparam logic [CW-1:0] AGREE_LAST = CW'(CONFIRM_CYC - 1);
  localparam logic [CW-1:0] TMR_LAST   = CW'(SUSPECT_MAX - 1);

  logic [CW-1:0] agree_q;
  logic [CW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agree_q <= '0;
      tmr_q   <= '0;
    end else if (!in_suspect_i) begin
      agree_q <= '0;
      tmr_q   <= '0;
    end else begin
      agree_q <= all_fault_i ? agree_q + 1'b1 : '0;
      tmr_q   <= tmr_q + 1'b1;
    end
  end

  assign confirm_hit_o = in_suspect_i && all_fault_i && (agree_q == AGREE_LAST);
  assign lapse_hit_o   = in_suspect_i && (tmr_q == TMR_LAST);

endmodule

// File: rtl/alarm_fsm_core.sv
module alarm_fsm_core
  import alarm_vote_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_fault_i,
  input  logic          any_invalid_i,
  input  logic          confirm_hit_i,
  input  logic          lapse_hit_i,
  input  logic          maint_req_i,
  output alarm_state_e  state_q_o,
  output alarm_state_e  state_d_o,
  output logic          rpt_valid_o,
  output alarm_report_t rpt_o
);

  alarm_state_e  state_q, state_d;
  alarm_reason_e rsn_d;
  logic          reject;
  logic          clean;
  logic          report;

  assign clean = !any_fault_i && !any_invalid_i;

  always_comb begin
    state_d = state_q;
    rsn_d   = RSN_NONE;
    reject  = 1'b0;
    case (state_q)
      ST_NORMAL: begin
        if (any_invalid_i)    state_d = ST_UNTRUSTED;
        else if (any_fault_i) state_d = ST_SUSPECT;
      end
      ST_SUSPECT: begin
        if (any_invalid_i)      state_d = ST_UNTRUSTED;
        else if (confirm_hit_i) state_d = ST_CONFIRMED;
        else if (lapse_hit_i) begin
          state_d = ST_NORMAL;
          rsn_d   = RSN_LAPSE;
        end
      end
      ST_CONFIRMED: state_d = ST_LATCHED;
      ST_LATCHED, ST_UNTRUSTED: begin
        if (maint_req_i) begin
          if (clean) begin
            state_d = ST_NORMAL;
            rsn_d   = RSN_CLEAR;
          end else begin
            reject = 1'b1;
            rsn_d  = RSN_REJECT;
          end
        end
      end
      default: state_d = ST_UNTRUSTED;
    endcase
  end

  assign report = (state_d != state_q) || reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_NORMAL;
      rpt_valid_o <= 1'b0;
      rpt_o       <= '0;
    end else begin
      state_q     <= state_d;
      rpt_valid_o <= report;
      if (report) rpt_o <= '{from_st: state_q, to_st: state_d, reason: rsn_d};
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/alarm_out_drv.sv
module alarm_out_drv
  import alarm_vote_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  alarm_state_e state_q_i,
  input  alarm_state_e state_d_i,
  output logic         alert_o,
  output logic         hard_act_o,
  output logic         iso_ok_o
);

  logic iso_ok_q;

  assign alert_o    = (state_q_i == ST_CONFIRMED) || (state_q_i == ST_LATCHED) ||
                      (state_q_i == ST_UNTRUSTED);
  assign hard_act_o = (state_q_i == ST_LATCHED);

  // Registered so the line sits at its alarm level throughout reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iso_ok_q <= 1'b0;
    else        iso_ok_q <= (state_d_i == ST_NORMAL) || (state_d_i == ST_SUSPECT);
  end

  assign iso_ok_o = iso_ok_q;

endmodule

// File: rtl/alarm_vote_fsm.sv
module alarm_vote_fsm
  import alarm_vote_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CONFIRM_CYC = 4,
  parameter int SUSPECT_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_fault_i,
  input  logic [NUM_CH-1:0] chan_invalid_i,
  input  logic              maint_req_i,
  output logic              alert_o,
  output logic              hard_act_o,
  output logic              iso_ok_o,
  output logic              log_valid_o,
  output logic [2:0]        log_from_o,
  output logic [2:0]        log_to_o,
  output logic [1:0]        log_reason_o
);

  logic          any_fault, all_fault, any_invalid;
  logic          confirm_hit, lapse_hit;
  alarm_state_e  state_q, state_d;
  alarm_report_t rpt;

  chan_vote #(.NUM_CH(NUM_CH)) u_vote (
    .fault_i       (chan_fault_i),
    .invalid_i     (chan_invalid_i),
    .any_fault_o   (any_fault),
    .all_fault_o   (all_fault),
    .any_invalid_o (any_invalid)
  );

  suspect_timer #(.CONFIRM_CYC(CONFIRM_CYC), .SUSPECT_MAX(SUSPECT_MAX)) u_tmr (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_suspect_i  (state_q == ST_SUSPECT),
    .all_fault_i   (all_fault),
    .confirm_hit_o (confirm_hit),
    .lapse_hit_o   (lapse_hit)
  );

  alarm_fsm_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_fault_i   (any_fault),
    .any_invalid_i (any_invalid),
    .confirm_hit_i (confirm_hit),
    .lapse_hit_i   (lapse_hit),
    .maint_req_i   (maint_req_i),
    .state_q_o     (state_q),
    .state_d_o     (state_d),
    .rpt_valid_o   (log_valid_o),
    .rpt_o         (rpt)
  );

  alarm_out_drv u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q_i  (state_q),
    .state_d_i  (state_d),
    .alert_o    (alert_o),
    .hard_act_o (hard_act_o),
    .iso_ok_o   (iso_ok_o)
  );

  assign log_from_o   = rpt.from_st;
  assign log_to_o     = rpt.to_st;
  assign log_reason_o = rpt.reason;

endmodule

// File: rtl/alarm_vote_fsm_chk.sv
module alarm_vote_fsm_chk
  import alarm_vote_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CONFIRM_CYC = 4,
  parameter int SUSPECT_MAX = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_fault_i,
  input logic [NUM_CH-1:0] chan_invalid_i,
  input logic              maint_req_i,
  input logic              alert_o,
  input logic              hard_act_o,
  input logic              iso_ok_o,
  input logic              log_valid_o,
  input logic [2:0]        log_from_o,
  input logic [2:0]        log_to_o,
  input logic [1:0]        log_reason_o
);

  localparam int SW = $clog2(SUSPECT_MAX + 2) + 1;
  logic [SW-1:0] susp_cnt;

  // Cycles spent in Suspect, reconstructed from the report stream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  susp_cnt <= '0;
    else if (log_valid_o && log_to_o == ST_SUSPECT) susp_cnt <= SW'(1);
    else if (log_valid_o)                        susp_cnt <= '0;
    else if (susp_cnt != '0)                     susp_cnt <= susp_cnt + 1'b1;
  end

  assert_suspect_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_cnt <= SW'(SUSPECT_MAX));

  assert_confirm_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && log_to_o == ST_CONFIRMED) |-> $past(&chan_fault_i));

  assert_hard_rise_from_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_act_o) |-> (log_valid_o && log_from_o == ST_CONFIRMED));

  assert_hard_release_by_maint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hard_act_o) |-> ($past(maint_req_i) && log_valid_o && log_reason_o == RSN_CLEAR));

  assert_invalid_not_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_invalid_i) |=> !iso_ok_o);

  assert_reject_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && log_reason_o == RSN_REJECT) |-> (log_from_o == log_to_o && $stable(hard_act_o)));

  assert_hard_implies_alert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hard_act_o |-> (alert_o && !iso_ok_o));

endmodule

bind alarm_vote_fsm alarm_vote_fsm_chk #(
  .NUM_CH(NUM_CH), .CONFIRM_CYC(CONFIRM_CYC), .SUSPECT_MAX(SUSPECT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_fault_i(chan_fault_i), .chan_invalid_i(chan_invalid_i),
  .maint_req_i(maint_req_i), .alert_o(alert_o), .hard_act_o(hard_act_o), .iso_ok_o(iso_ok_o),
  .log_valid_o(log_valid_o), .log_from_o(log_from_o), .log_to_o(log_to_o),
  .log_reason_o(log_reason_o)
);

// File: tb/tb_alarm_vote_fsm.sv
module tb_alarm_vote_fsm;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] flt = 2'b00;
  logic [1:0] inv = 2'b00;
  logic       maint = 1'b0;
  logic       alert, hard, iso_ok, logv;
  logic [2:0] lfrom, lto;
  logic [1:0] lrsn;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] rec;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  alarm_vote_fsm dut (
    .clk(clk), .rst_n(rst_n), .chan_fault_i(flt), .chan_invalid_i(inv),
    .maint_req_i(maint), .alert_o(alert), .hard_act_o(hard), .iso_ok_o(iso_ok),
    .log_valid_o(logv), .log_from_o(lfrom), .log_to_o(lto), .log_reason_o(lrsn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int f, input int t, input int r, input string req);
    exp_t e;
    e.rec = {f[2:0], t[2:0], r[1:0]};
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare each report a quarter period after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && logv) begin
        exp_t e;
        logic [7:0] got;
        got = {lfrom, lto, lrsn};
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R12 unexpected report actual=%0h expected=none", got);
        end else begin
          e = exp_q.pop_front();
          if (got !== e.rec) begin
            n_bad++;
            $display("FAIL %s report actual=%0h expected=%0h", e.req, got, e.rec);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "alert in reset", int'(alert), 0);
    chk("R1", "hard in reset", int'(hard), 0);
    chk("R1", "iso_ok in reset", int'(iso_ok), 0);
    chk("R1", "log_valid in reset", int'(logv), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "iso_ok after release", int'(iso_ok), 1);
    chk("R11", "alert in Normal", int'(alert), 0);

    // R2 / R4: single short fault, suspect lapses after 16 cycles
    push(0, 1, 0, "R2");
    push(1, 0, 1, "R4");
    flt = 2'b01;
    tick(1);
    chk("R2", "report on entry", int'(logv), 1);
    chk("R11", "iso_ok in Suspect", int'(iso_ok), 1);
    chk("R11", "alert in Suspect", int'(alert), 0);
    flt = 2'b00;
    tick(1);
    chk("R12", "strobe one cycle", int'(logv), 0);
    tick(14);
    chk("R4", "no early lapse", int'(logv), 0);
    tick(1);
    chk("R4", "lapse reason", int'(lrsn), 1);
    tick(2);

    // R3: persistent single-channel fault never confirms
    push(0, 1, 0, "R3");
    push(1, 0, 1, "R3");
    flt = 2'b10;
    tick(17);
    chk("R3", "single channel lapses to Normal", int'(lto), 0);
    chk("R3", "no hard action", int'(hard), 0);
    flt = 2'b00;
    tick(2);

    // R3 / R5: agreement broken once, then held
    push(0, 1, 0, "R3");
    push(1, 2, 0, "R3");
    push(2, 3, 0, "R5");
    flt = 2'b11;
    tick(3);
    flt = 2'b01;
    tick(1);
    flt = 2'b11;
    tick(3);
    chk("R3", "broken agreement restarts count", int'(logv), 0);
    tick(1);
    chk("R3", "confirmed after full agreement", int'(lto), 2);
    chk("R11", "alert in Confirmed", int'(alert), 1);
    chk("R5", "no hard action in Confirmed", int'(hard), 0);
    chk("R11", "iso_ok in Confirmed", int'(iso_ok), 0);
    tick(1);
    chk("R5", "hard action in Latched", int'(hard), 1);
    chk("R11", "iso_ok in Latched", int'(iso_ok), 0);

    // R6: latch holds through clearing and invalid toggles
    flt = 2'b00;
    inv = 2'b11;
    tick(4);
    chk("R6", "latched with invalid", int'(hard), 1);
    inv = 2'b00;
    tick(2);
    chk("R6", "latched after inputs clear", int'(hard), 1);
    chk("R6", "no report", int'(logv), 0);

    // R8: maintenance with fault present is refused
    push(3, 3, 3, "R8");
    flt = 2'b01;
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    chk("R8", "reject reason", int'(lrsn), 3);
    chk("R8", "hard kept", int'(hard), 1);
    flt = 2'b00;
    tick(2);
    chk("R8", "still latched", int'(hard), 1);

    // R7: clean maintenance clears
    push(3, 0, 2, "R7");
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    chk("R7", "hard released", int'(hard), 0);
    chk("R7", "alert released", int'(alert), 0);
    chk("R7", "iso_ok restored", int'(iso_ok), 1);
    tick(1);
    chk("R12", "strobe dropped", int'(logv), 0);
    tick(1);

    // R10: maintenance in Normal ignored
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    chk("R10", "no report", int'(logv), 0);
    chk("R10", "iso_ok unchanged", int'(iso_ok), 1);
    chk("R10", "alert unchanged", int'(alert), 0);
    tick(2);

    // R9: invalid in Normal
    push(0, 4, 0, "R9");
    inv = 2'b01;
    tick(1);
    chk("R9", "alert in Untrusted", int'(alert), 1);
    chk("R9", "iso_ok in Untrusted", int'(iso_ok), 0);
    chk("R9", "no hard action", int'(hard), 0);
    inv = 2'b00;
    tick(3);
    chk("R9", "untrusted held after validity returns", int'(iso_ok), 0);
    push(4, 4, 3, "R8");
    flt = 2'b10;
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    chk("R8", "reject in Untrusted", int'(lrsn), 3);
    flt = 2'b00;
    push(4, 0, 2, "R9");
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    chk("R9", "clean exit from Untrusted", int'(iso_ok), 1);
    tick(2);

    // R9: invalid during Suspect
    push(0, 1, 0, "R2");
    flt = 2'b01;
    tick(1);
    push(1, 4, 0, "R9");
    inv = 2'b10;
    tick(1);
    chk("R9", "Suspect to Untrusted", int'(lto), 4);
    chk("R9", "iso_ok low", int'(iso_ok), 0);
    flt = 2'b00;
    inv = 2'b00;
    push(4, 0, 2, "R9");
    maint = 1'b1;
    tick(1);
    maint = 1'b0;
    tick(3);

    chk("R12", "all expected reports seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule